// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects level-sensitive interrupt requests into two local groups of eight bits each and a third, shared group of eight mappable sources. The mappable sources have one common status register but two independent mask registers. Each masked result folds down into one fixed bit of a local group: mask 0 feeds bit 7 of local group 0, and mask 1 feeds bit 3 of local group 1. Each local group drives one CPU interrupt line. That line is the OR of its status bits ANDed with its mask.

Software reaches the block over a simple 32-bit register bus with a word-aligned byte address. It reads status, sets masks, and clears two sticky timer flags through a write-only clear register. The timer counters are not part of the block. Only their pending flags are held here. Each flag is set by a one-cycle pulse from its timer and is also visible on an output pin.

Register word index (`bus_addr[4:2]`): 0 local 0 status (read-only), 1 local 0 mask, 2 local 1 status (read-only), 3 local 1 mask, 4 map status (read-only), 5 map mask 0, 6 map mask 1, 7 timer clear (write-only, reads zero).

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every mask register reads zero, both timer flags are clear and both CPU interrupt outputs are low.
- R2: Local status registers (byte address 0x00 for group 0, 0x08 for group 1) show the request inputs sampled at the previous clock edge.
- R3: `cpu_irq[g]` is high exactly when some bit of group g status AND group g mask is set.
- R4: The map status register at 0x10 shows the sampled mappable requests. A nonzero AND of map status with map mask 0 (0x14) sets local 0 status bit 7.
- R5: A nonzero AND of map status with map mask 1 (0x18) sets local 1 status bit 3.
- R6: The request input bits at the cascade positions (group 0 bit 7, group 1 bit 3) are ignored. Those status bits come only from the mappable group.
- R7: Mask registers (0x04, 0x0C, 0x14, 0x18) take the low 8 bits of a write and read them back. Bits 31:8 of every read are zero. Writes to status addresses have no effect.
- R8: A one-cycle pulse on `tmr_pulse[i]` sets timer flag i on the next edge. The flag then holds until it is cleared, and it drives `tmr_irq[i]`.
- R9: A write to 0x1C clears timer flag 0 where data bit 0 is 1 and timer flag 1 where data bit 1 is 1, so 0x03 clears both. Reading 0x1C returns zero.
- R10: When a timer pulse and a clear of the same flag fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| grp0_req | input | 8 | Local group 0 request levels |
| grp1_req | input | 8 | Local group 1 request levels |
| map_req | input | 8 | Mappable request levels |
| tmr_pulse | input | 2 | Timer event pulses |
| cpu_irq | output | 2 | CPU interrupt lines, one per local group |
| tmr_irq | output | 2 | Sticky timer flags |

## Verification
The bench goes after the cascade paths. A design that wires map mask 0 into the wrong group would raise the wrong CPU line in the mapped-source vectors. A design that lets the raw request bit at a cascade position through would show status 0xFF instead of 0x7F when every input is high. The timer checks clear one flag while the other is held, so a clear that ignores the data bit shows up as a lost flag. A pulse and a clear in the same cycle show whether a design lets the clear win. A write of all ones to a mask exposes upper bits that were not cut to zero on readback.

// File: rtl/irq_cc_pkg.sv
package irq_cc_pkg;
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_L0_STAT = 3'd0,
        RG_L0_MASK = 3'd1,
        RG_L1_STAT = 3'd2,
        RG_L1_MASK = 3'd3,
        RG_MP_STAT = 3'd4,
        RG_MP_MSK0 = 3'd5,
        RG_MP_MSK1 = 3'd6,
        RG_TM_CLR  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/irq_local_group.sv
module irq_local_group #(
    parameter int SRC_N    = 8,
    parameter int CASC_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] req,
    input  logic             casc,
    input  logic             mask_we,
    input  logic [SRC_N-1:0] mask_wdata,
    output logic [SRC_N-1:0] status,
    output logic [SRC_N-1:0] mask,
    output logic             irq
);
    logic [SRC_N-1:0] samp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            mask   <= '0;
        end else begin
            samp_q <= req;
            if (mask_we) mask <= mask_wdata;
        end
    end

    // Cascade position takes the folded mappable result, never the raw input.
    for (genvar b = 0; b < SRC_N; b++) begin : g_bit
        if (b == CASC_BIT) begin : g_casc
            assign status[b] = casc;
        end else begin : g_raw
            assign status[b] = samp_q[b];
        end
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/irq_map_unit.sv
module irq_map_unit #(
    parameter int SRC_N  = 8,
    parameter int DEST_N = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SRC_N-1:0]              req,
    input  logic [DEST_N-1:0]             mask_we,
    input  logic [SRC_N-1:0]              mask_wdata,
    output logic [SRC_N-1:0]              status,
    output logic [DEST_N-1:0][SRC_N-1:0]  mask,
    output logic [DEST_N-1:0]             casc
);
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= req;
    end

    for (genvar d = 0; d < DEST_N; d++) begin : g_dest
        always_ff @(posedge clk) begin
            if (!rst_n)          mask[d] <= '0;
            else if (mask_we[d]) mask[d] <= mask_wdata;
        end
        assign casc[d] = |(status & mask[d]);
    end
endmodule

// File: rtl/irq_timer_flags.sv
module irq_timer_flags #(
    parameter int TMR_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_N-1:0] pulse,
    input  logic             clr_we,
    input  logic [TMR_N-1:0] clr_bits,
    output logic [TMR_N-1:0] flag
);
    for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (!rst_n)                     flag[t] <= 1'b0;
            else if (pulse[t])              flag[t] <= 1'b1;
            else if (clr_we && clr_bits[t]) flag[t] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int SRC_N     = 8,
    parameter int TMR_N     = 2,
    parameter int CASC0_BIT = 7,
    parameter int CASC1_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  grp0_req,
    input  logic [SRC_N-1:0]  grp1_req,
    input  logic [SRC_N-1:0]  map_req,
    input  logic [TMR_N-1:0]  tmr_pulse,
    output logic [1:0]        cpu_irq,
    output logic [TMR_N-1:0]  tmr_irq
);
    localparam int PAD_W = DATA_W - SRC_N;

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr[REG_IDX_W+1:2]);

    logic [SRC_N-1:0]            l0_stat, l0_mask, l1_stat, l1_mask, mp_stat;
    logic [1:0][SRC_N-1:0]       mp_mask;
    logic [1:0]                  mp_casc;
    logic [1:0]                  mp_we;

    assign mp_we[0] = bus_wr && (sel == RG_MP_MSK0);
    assign mp_we[1] = bus_wr && (sel == RG_MP_MSK1);

    irq_map_unit #(.SRC_N(SRC_N), .DEST_N(2)) u_map (
        .clk(clk), .rst_n(rst_n), .req(map_req),
        .mask_we(mp_we), .mask_wdata(bus_wdata[SRC_N-1:0]),
        .status(mp_stat), .mask(mp_mask), .casc(mp_casc)
    );

    irq_local_group #(.SRC_N(SRC_N), .CASC_BIT(CASC0_BIT)) u_grp0 (
        .clk(clk), .rst_n(rst_n), .req(grp0_req), .casc(mp_casc[0]),
        .mask_we(bus_wr && (sel == RG_L0_MASK)),
        .mask_wdata(bus_wdata[SRC_N-1:0]),
        .status(l0_stat), .mask(l0_mask), .irq(cpu_irq[0])
    );

    irq_local_group #(.SRC_N(SRC_N), .CASC_BIT(CASC1_BIT)) u_grp1 (
        .clk(clk), .rst_n(rst_n), .req(grp1_req), .casc(mp_casc[1]),
        .mask_we(bus_wr && (sel == RG_L1_MASK)),
        .mask_wdata(bus_wdata[SRC_N-1:0]),
        .status(l1_stat), .mask(l1_mask), .irq(cpu_irq[1])
    );

    irq_timer_flags #(.TMR_N(TMR_N)) u_tmr (
        .clk(clk), .rst_n(rst_n), .pulse(tmr_pulse),
        .clr_we(bus_wr && (sel == RG_TM_CLR)),
        .clr_bits(bus_wdata[TMR_N-1:0]),
        .flag(tmr_irq)
    );

    logic [SRC_N-1:0] rd_byte;
    always_comb begin
        unique case (sel)
            RG_L0_STAT: rd_byte = l0_stat;
            RG_L0_MASK: rd_byte = l0_mask;
            RG_L1_STAT: rd_byte = l1_stat;
            RG_L1_MASK: rd_byte = l1_mask;
            RG_MP_STAT: rd_byte = mp_stat;
            RG_MP_MSK0: rd_byte = mp_mask[0];
            RG_MP_MSK1: rd_byte = mp_mask[1];
            RG_TM_CLR:  rd_byte = '0;
            default:    rd_byte = '0;
        endcase
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_byte};
endmodule

// File: rtl/irq_cc_chk.sv
module irq_cc_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int SRC_N  = 8,
    parameter int TMR_N  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SRC_N-1:0]  grp0_req,
    input logic [SRC_N-1:0]  map_req,
    input logic [TMR_N-1:0]  tmr_pulse,
    input logic [1:0]        cpu_irq,
    input logic [TMR_N-1:0]  tmr_irq
);
    logic clr_hit;
    assign clr_hit = bus_wr && (bus_addr[4:2] == 3'd7);

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:SRC_N] == '0); // R7

    AST_TMR_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pulse[0] |=> tmr_irq[0]); // R10

    AST_TMR_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_irq[0] && !(clr_hit && bus_wdata[0])) |=> tmr_irq[0]); // R8

    AST_TMR_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && bus_wdata[1] && !tmr_pulse[1]) |=> !tmr_irq[1]); // R9

    AST_IRQ0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grp0_req) == '0 && $past(map_req) == '0) |-> !cpu_irq[0]); // R3
endmodule

bind irq_cascade_ctrl irq_cc_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_N(SRC_N), .TMR_N(TMR_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp0_req(grp0_req),
    .map_req(map_req), .tmr_pulse(tmr_pulse), .cpu_irq(cpu_irq),
    .tmr_irq(tmr_irq)
);

// File: tb/tb_irq_cascade_ctrl.sv
module tb_irq_cascade_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  grp0_req = '0, grp1_req = '0, map_req = '0;
    logic [1:0]  tmr_pulse = '0;
    logic [1:0]  cpu_irq, tmr_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_cascade_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp0_req(grp0_req),
        .grp1_req(grp1_req), .map_req(map_req), .tmr_pulse(tmr_pulse),
        .cpu_irq(cpu_irq), .tmr_irq(tmr_irq)
    );

    typedef struct packed {
        logic [7:0] g0, g1, mp, k0, k1, q0, q1, s0, s1;
        logic [1:0] irq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 2'b01},
        '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 2'b00},
        '{8'h00, 8'h20, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 8'h20, 2'b10},
        '{8'h00, 8'h00, 8'h04, 8'h80, 8'h00, 8'h04, 8'h00, 8'h80, 8'h00, 2'b01},
        '{8'h00, 8'h00, 8'h04, 8'h80, 8'h08, 8'h00, 8'h04, 8'h00, 8'h08, 2'b10},
        '{8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h04, 8'h00, 8'h80, 8'h00, 2'b00},
        '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h7F, 8'hF7, 2'b11},
        '{8'h80, 8'h08, 8'h00, 8'h80, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(5'h04, r); check("R1 l0 mask", r, 0);
        rd(5'h0C, r); check("R1 l1 mask", r, 0);
        rd(5'h14, r); check("R1 map mask0", r, 0);
        rd(5'h18, r); check("R1 map mask1", r, 0);
        check("R1 cpu_irq", {30'd0, cpu_irq}, 0);
        check("R1 tmr_irq", {30'd0, tmr_irq}, 0);

        // Table walk: R2 R3 R4 R5 R6
        foreach (VECS[i]) begin
            wr(5'h04, {24'd0, VECS[i].k0});
            wr(5'h0C, {24'd0, VECS[i].k1});
            wr(5'h14, {24'd0, VECS[i].q0});
            wr(5'h18, {24'd0, VECS[i].q1});
            grp0_req = VECS[i].g0; grp1_req = VECS[i].g1; map_req = VECS[i].mp;
            @(negedge clk);
            rd(5'h00, r); check($sformatf("R2/R4/R6 vec%0d l0 status", i), r, {24'd0, VECS[i].s0});
            rd(5'h08, r); check($sformatf("R2/R5/R6 vec%0d l1 status", i), r, {24'd0, VECS[i].s1});
            rd(5'h10, r); check($sformatf("R4 vec%0d map status", i), r, {24'd0, VECS[i].mp});
            check($sformatf("R3 vec%0d cpu_irq", i), {30'd0, cpu_irq}, {30'd0, VECS[i].irq});
        end
        grp0_req = '0; grp1_req = '0; map_req = '0;

        // R7 mask width and status write ignored
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, r); check("R7 mask readback", r, 32'h0000_00FF);
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h00, r); check("R7 status write ignored l0", r, 0);
        rd(5'h10, r); check("R7 status write ignored map", r, 0);

        // R8 set and hold
        @(negedge clk); tmr_pulse = 2'b11;
        @(negedge clk); tmr_pulse = 2'b00;
        check("R8 flags set", {30'd0, tmr_irq}, 3);
        repeat (4) @(negedge clk);
        check("R8 flags held", {30'd0, tmr_irq}, 3);
        // R9 selective clear
        wr(5'h1C, 32'h1);
        check("R9 clear bit0 only", {30'd0, tmr_irq}, 2);
        rd(5'h1C, r); check("R9 clear reg reads zero", r, 0);
        wr(5'h1C, 32'h3);
        check("R9 clear both", {30'd0, tmr_irq}, 0);
        // R10 set wins
        @(negedge clk);
        tmr_pulse = 2'b01; bus_wr = 1'b1; bus_addr = 5'h1C; bus_wdata = 32'h3;
        @(negedge clk);
        tmr_pulse = 2'b00; bus_wr = 1'b0;
        check("R10 pulse beats clear", {30'd0, tmr_irq}, 1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule